// File: doc/BRIEF.md
# Dead-Time Pulse Pattern Generator

This block drives an eight-bit (by default) pulse output port from a staged pattern word. A free-running counter runs from zero up to a programmed period value and then wraps. At the wrap, every output that must fall takes its new value at once. Every output that must rise waits until the counter reaches a second, smaller value: the dead-time margin. Complementary phases therefore never overlap, and the gap between them equals the margin.

The outputs are split into fixed-width groups. Each group has its own switch that chooses two-phase (dead-time) update or plain copy, and its own trigger switch that ties the group to the timebase or leaves it untouched. Each output bit also has an update enable. At each margin match the block raises a one-cycle reload request and sets a sticky flag, so software or a DMA engine can stage the next pattern before the next wrap. Loading the words 0x95, 0x65, 0x59, 0x56 in a loop produces a four-phase complementary drive. The bit pairs (0,1), (2,3), (4,5) and (6,7) are never both high.

Configuration goes through a small write-only port. Address 0 holds the period, 1 the margin, 2 the staged pattern and 3 the per-bit update enables. Address 4 is control: bit 0 run, bit 1 request enable, bits 2 and up the per-group dead-time selects, and the bits after them the per-group trigger selects. A write to address 5 with bit 0 set clears the flag.

Top module: `dtpulse_out`

## Requirements
- R1: While running, the counter steps by one each cycle and wraps to zero in the cycle after it reaches the period value, so one update cycle lasts period+1 clocks.
- R2: In a dead-time group, at the period match each enabled output that is 1 and whose staged bit is 0 goes to 0, and all other outputs hold.
- R3: In a dead-time group, at the margin match each enabled output that is 0 and whose staged bit is 1 goes to 1. No output of that group rises at any other time.
- R4: A margin match sets the sticky flag. When the request enable (control bit 1) is set, it also drives reload_req high for exactly one cycle. Both become visible in the same cycle as the rising outputs.
- R5: Writing 1 to bit 0 at address 5 clears the flag. A margin match in the same cycle wins over the clear.
- R6: In a group whose dead-time select is 0, all enabled outputs copy the staged bits at the period match.
- R7: An output whose update enable bit (address 3) is 0 holds its value through both matches.
- R8: A group whose trigger select is 0 holds all of its outputs.
- R9: With run (control bit 0) cleared, the counter and the outputs freeze and no request is raised. Setting run again resumes from the frozen count.
- R10: If the margin is programmed at or above the period, no margin match occurs: no output rises, and no request or flag is produced.
- R11: Loading the sequence 0x95, 0x65, 0x59, 0x56 at successive requests yields the pattern 0x95, 0x05, 0x65, 0x41, 0x59, 0x50, 0x56, 0x14, 0x95. Pairs (0,1), (2,3), (4,5) and (6,7) are never both high.
- R12: After reset, the outputs, reload_req and the flag are all 0, and the counter is stopped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register address |
| wr_data | input | DATA_W | Register write data |
| pulse_out | output | NUM_GRP*GRP_W | Pulse output port |
| reload_req | output | 1 | One-cycle request to load the next pattern |
| margin_flag | output | 1 | Sticky margin-match flag |

## Verification
The bench builds the block with an 8-bit counter, two groups of four bits and 16-bit write data. It uses a period of 9 and a margin of 3, which gives ten-clock update cycles. The short cycles let every period match and margin match be landed on an exact clock count after each request. A short gap between the two matches makes any rise or fall applied at the wrong match show up as a wrong pattern. Running two groups makes it possible to mix one dead-time group with one copy group, or one triggered group with one idle group, in a single pass.

// File: rtl/dtpulse_pkg.sv
package dtpulse_pkg;

   typedef enum logic [2:0] {
      ADR_PERIOD = 3'd0,
      ADR_MARGIN = 3'd1,
      ADR_NDATA  = 3'd2,
      ADR_OEN    = 3'd3,
      ADR_CTRL   = 3'd4,
      ADR_FLAG   = 3'd5
   } dtp_addr_e;

   localparam int CTL_RUN      = 0;
   localparam int CTL_REQEN    = 1;
   localparam int CTL_NOV_BASE = 2;

   function automatic int ctl_width(input int ngrp);
      return CTL_NOV_BASE + 2 * ngrp;
   endfunction

   function automatic int ctl_trig_base(input int ngrp);
      return CTL_NOV_BASE + ngrp;
   endfunction

endpackage

// File: rtl/dtpulse_regs.sv
module dtpulse_regs
   import dtpulse_pkg::*;
#(
   parameter int CNT_W   = 16,
   parameter int OUT_W   = 8,
   parameter int NUM_GRP = 2,
   parameter int DATA_W  = 16
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               wr_en,
   input  logic [2:0]         wr_addr,
   input  logic [DATA_W-1:0]  wr_data,
   output logic [CNT_W-1:0]   period_q,
   output logic [CNT_W-1:0]   margin_q,
   output logic [OUT_W-1:0]   ndata_q,
   output logic [OUT_W-1:0]   oen_q,
   output logic               run_q,
   output logic               reqen_q,
   output logic [NUM_GRP-1:0] nov_q,
   output logic [NUM_GRP-1:0] trig_q,
   output logic               flag_clr
);
   localparam int CTL_W  = ctl_width(NUM_GRP);
   localparam int TRIG_B = ctl_trig_base(NUM_GRP);

   if (DATA_W < CNT_W || DATA_W < OUT_W || DATA_W < CTL_W) begin : g_bad_width
      $error("dtpulse_regs: DATA_W too narrow for the register fields");
   end

   logic [CTL_W-1:0] ctrl_q;
   logic             unused_wdata;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         period_q <= '0;
         margin_q <= '0;
         ndata_q  <= '0;
         oen_q    <= '0;
         ctrl_q   <= '0;
      end else if (wr_en) begin
         case (wr_addr)
            ADR_PERIOD: period_q <= wr_data[CNT_W-1:0];
            ADR_MARGIN: margin_q <= wr_data[CNT_W-1:0];
            ADR_NDATA:  ndata_q  <= wr_data[OUT_W-1:0];
            ADR_OEN:    oen_q    <= wr_data[OUT_W-1:0];
            ADR_CTRL:   ctrl_q   <= wr_data[CTL_W-1:0];
            default: ;
         endcase
      end
   end

   assign run_q    = ctrl_q[CTL_RUN];
   assign reqen_q  = ctrl_q[CTL_REQEN];
   assign nov_q    = ctrl_q[CTL_NOV_BASE +: NUM_GRP];
   assign trig_q   = ctrl_q[TRIG_B +: NUM_GRP];
   assign flag_clr = wr_en && (wr_addr == ADR_FLAG) && wr_data[0];
   assign unused_wdata = ^wr_data;

endmodule

// File: rtl/dtpulse_timebase.sv
module dtpulse_timebase #(
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic [CNT_W-1:0] period,
   input  logic [CNT_W-1:0] margin,
   output logic             hit_a,
   output logic             hit_b
);
   if (CNT_W < 2) begin : g_bad_cnt
      $error("dtpulse_timebase: CNT_W must be at least 2");
   end

   logic [CNT_W-1:0] cnt_q;
   logic             margin_ok;

   always_ff @(posedge clk) begin
      if (!rst_n)
         cnt_q <= '0;
      else if (run)
         cnt_q <= (cnt_q >= period) ? '0 : cnt_q + 1'b1;
   end

   assign margin_ok = margin < period;
   assign hit_b     = run && (cnt_q >= period);
   assign hit_a     = run && margin_ok && (cnt_q == margin);

   // R9: a stopped timebase keeps its count
   p_cnt_frozen_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !run |=> $stable(cnt_q));

   // R1: below the period the count moves by exactly one
   p_cnt_step_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (run && cnt_q < period) |=> (cnt_q == $past(cnt_q) + 1'b1));

endmodule

// File: rtl/dtpulse_group.sv
module dtpulse_group #(
   parameter int GRP_W = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             hit_a,
   input  logic             hit_b,
   input  logic             nov,
   input  logic             trig,
   input  logic [GRP_W-1:0] oen,
   input  logic [GRP_W-1:0] ndata,
   output logic [GRP_W-1:0] out_q
);
   if (GRP_W < 1) begin : g_bad_grp
      $error("dtpulse_group: GRP_W must be positive");
   end

   logic [GRP_W-1:0] fall_m, rise_m, nxt;

   always_comb begin
      fall_m = out_q & oen & ~ndata;
      rise_m = ~out_q & oen & ndata;
      nxt    = out_q;
      if (trig && hit_b)
         nxt = nov ? (out_q & ~fall_m) : ((out_q & ~oen) | (ndata & oen));
      else if (trig && nov && hit_a)
         nxt = out_q | rise_m;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) out_q <= '0;
      else        out_q <= nxt;
   end

   // R2: in dead-time mode nothing falls outside the period match
   p_fall_at_b_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (nov && !(trig && hit_b)) |=> ((~out_q & $past(out_q)) == '0));

   // R3: in dead-time mode nothing rises outside the margin match
   p_rise_at_a_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (nov && !(trig && hit_a)) |=> ((out_q & ~$past(out_q)) == '0));

endmodule

// File: rtl/dtpulse_out.sv
module dtpulse_out
   import dtpulse_pkg::*;
#(
   parameter int CNT_W   = 16,
   parameter int GRP_W   = 4,
   parameter int NUM_GRP = 2,
   parameter int DATA_W  = 16
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     wr_en,
   input  logic [2:0]               wr_addr,
   input  logic [DATA_W-1:0]        wr_data,
   output logic [NUM_GRP*GRP_W-1:0] pulse_out,
   output logic                     reload_req,
   output logic                     margin_flag
);
   localparam int OUT_W = NUM_GRP * GRP_W;

   if (NUM_GRP < 1) begin : g_bad_ngrp
      $error("dtpulse_out: NUM_GRP must be positive");
   end

   logic [CNT_W-1:0]   period_q, margin_q;
   logic [OUT_W-1:0]   ndata_q, oen_q;
   logic               run_q, reqen_q, flag_clr;
   logic [NUM_GRP-1:0] nov_q, trig_q;
   logic               hit_a, hit_b, hit_a_d;

   dtpulse_regs #(
      .CNT_W(CNT_W), .OUT_W(OUT_W), .NUM_GRP(NUM_GRP), .DATA_W(DATA_W)
   ) u_regs (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
      .period_q(period_q), .margin_q(margin_q), .ndata_q(ndata_q), .oen_q(oen_q),
      .run_q(run_q), .reqen_q(reqen_q), .nov_q(nov_q), .trig_q(trig_q),
      .flag_clr(flag_clr)
   );

   dtpulse_timebase #(.CNT_W(CNT_W)) u_tb (
      .clk(clk), .rst_n(rst_n), .run(run_q), .period(period_q), .margin(margin_q),
      .hit_a(hit_a), .hit_b(hit_b)
   );

   for (genvar g = 0; g < NUM_GRP; g++) begin : g_grp
      dtpulse_group #(.GRP_W(GRP_W)) u_grp (
         .clk(clk), .rst_n(rst_n), .hit_a(hit_a), .hit_b(hit_b),
         .nov(nov_q[g]), .trig(trig_q[g]),
         .oen(oen_q[g*GRP_W +: GRP_W]), .ndata(ndata_q[g*GRP_W +: GRP_W]),
         .out_q(pulse_out[g*GRP_W +: GRP_W])
      );
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         hit_a_d     <= 1'b0;
         reload_req  <= 1'b0;
         margin_flag <= 1'b0;
      end else begin
         hit_a_d    <= hit_a;
         reload_req <= hit_a && !hit_a_d && reqen_q;
         if (hit_a)         margin_flag <= 1'b1;
         else if (flag_clr) margin_flag <= 1'b0;
      end
   end

   // R4: the request never lasts more than one cycle
   p_req_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
      reload_req |=> !reload_req);

   // R4: a request always comes with the flag
   p_flag_with_req_r4: assert property (@(posedge clk) disable iff (!rst_n)
      reload_req |-> margin_flag);

   // R10: a request only follows a margin below the period
   p_req_margin_r10: assert property (@(posedge clk) disable iff (!rst_n)
      reload_req |-> $past(margin_q < period_q));

   // R9: outputs freeze while stopped
   p_out_frozen_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !run_q |=> $stable(pulse_out));

endmodule

// File: tb/dtpulse_out_tb_top.sv
module dtpulse_out_tb_top;
   localparam int CNT_W = 8, GRP_W = 4, NUM_GRP = 2, DATA_W = 16;
   localparam int OUT_W = NUM_GRP * GRP_W;
   localparam int P = 9, M = 3;
   localparam int NROW = 5;
   // each row: {staged word, value after period match, value after margin match}
   localparam logic [23:0] VEC [NROW] = '{
      {8'h65, 8'h05, 8'h65},
      {8'h59, 8'h41, 8'h59},
      {8'h56, 8'h50, 8'h56},
      {8'h95, 8'h14, 8'h95},
      {8'h65, 8'h05, 8'h65}
   };

   logic              clk = 1'b0, rst_n = 1'b0, wr_en = 1'b0;
   logic [2:0]        wr_addr = '0;
   logic [DATA_W-1:0] wr_data = '0;
   wire  [OUT_W-1:0]  pulse_out;
   wire               reload_req, margin_flag;
   int checks = 0, errors = 0, req_count = 0, pair_viol = 0, rc = 0;

   always #10 clk = ~clk;

   dtpulse_out #(.CNT_W(CNT_W), .GRP_W(GRP_W), .NUM_GRP(NUM_GRP), .DATA_W(DATA_W)) dut_i (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
      .pulse_out(pulse_out), .reload_req(reload_req), .margin_flag(margin_flag)
   );

   always @(negedge clk) begin
      if (rst_n) begin
         if (reload_req) req_count++;
         for (int k = 0; k < OUT_W / 2; k++)
            if (pulse_out[2*k] && pulse_out[2*k+1]) pair_viol++;
      end
   end

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [2:0] a, input logic [DATA_W-1:0] d);
      wr_addr = a; wr_data = d; wr_en = 1'b1;
      @(posedge clk);
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic wait_n(input int n);
      repeat (n) @(posedge clk);
      @(negedge clk);
   endtask

   task automatic wait_req();
      int t = 0;
      while (!reload_req && t < 2000) begin
         @(negedge clk);
         t++;
      end
      check("R4 request arrives", reload_req, 1'b1);
   endtask

   initial begin
      #(20 * 150000);
      errors++;
      $display("FAIL R4 watchdog actual hung expected finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      check("R12 out after reset", pulse_out, 8'h00);
      check("R12 req after reset", reload_req, 1'b0);
      check("R12 flag after reset", margin_flag, 1'b0);

      wr(3'd0, P);
      wr(3'd1, M);
      wr(3'd2, 16'h95);
      wr(3'd3, 16'hFF);
      wait_n(5);
      check("R12 stopped after reset", pulse_out, 8'h00);
      wr(3'd4, 16'h3F);
      wait_req();
      check("R3 first rise", pulse_out, 8'h95);
      check("R4 flag set", margin_flag, 1'b1);

      // R11 table walk: four-phase complementary sequence
      for (int i = 0; i < NROW; i++) begin
         wr(3'd2, {8'h00, VEC[i][23:16]});
         check("R4 request one cycle", reload_req, 1'b0);
         wait_n(P - M - 1);
         check("R2 R11 period match (R1 timing)", pulse_out, VEC[i][15:8]);
         wait_n(M + 1);
         check("R3 R11 margin match", pulse_out, VEC[i][7:0]);
         check("R4 request at margin", reload_req, 1'b1);
      end

      // R9 freeze and R5 flag clear
      wr(3'd4, 16'h3E);
      check("R5 flag before clear", margin_flag, 1'b1);
      wr(3'd5, 16'h1);
      check("R5 flag cleared", margin_flag, 1'b0);
      rc = req_count;
      wait_n(30);
      check("R9 outputs frozen", pulse_out, 8'h65);
      check("R9 no request while stopped", req_count - rc, 0);
      wr(3'd4, 16'h3F);
      wait_req();
      check("R9 resume", pulse_out, 8'h65);

      // R6 group 1 in copy mode
      wr(3'd4, 16'h37);
      wr(3'd2, 16'h59);
      wait_n(P - M - 2);
      check("R6 copy at period match", pulse_out, 8'h51);
      wait_n(M + 1);
      check("R6 margin match", pulse_out, 8'h59);

      // R7 upper bits not enabled
      wr(3'd3, 16'h0F);
      wr(3'd2, 16'h95);
      wait_n(P - M - 2);
      check("R7 enable at period match", pulse_out, 8'h51);
      wait_n(M + 1);
      check("R7 enable at margin match", pulse_out, 8'h55);

      // R8 group 1 trigger off
      wr(3'd4, 16'h1F);
      wr(3'd3, 16'hFF);
      wr(3'd2, 16'h56);
      wait_n(P - M - 3);
      check("R8 trigger off period match", pulse_out, 8'h54);
      wait_n(M + 1);
      check("R8 trigger off margin match", pulse_out, 8'h56);

      // R10 margin at the period
      wr(3'd4, 16'h3F);
      wr(3'd1, P);
      wr(3'd2, 16'h95);
      wait_n(P - M - 3);
      check("R10 fall still applied", pulse_out, 8'h14);
      rc = req_count;
      wait_n(3 * (P + 1));
      check("R10 no rise", pulse_out, 8'h14);
      check("R10 no request", req_count - rc, 0);

      check("R11 no pair both high", pair_viol, 0);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule